// File: doc/BRIEF.md
# Board Interrupt Level Controller

This block collects thirteen level-sensitive interrupt lines from board peripherals and presents them to the CPU as one 4-bit interrupt-level code. Each line sits at a fixed, non-contiguous bit of a 16-bit monitor word and has a fixed priority number. Software enables lines through a 16-bit mask register. The code driven to the CPU is the winning priority number inverted, so an idle board shows 0 and the most urgent line shows 15.

The same block holds a small 64-byte register window on a simple synchronous bus: the mask register, a fixed version word, a power-off control that raises a one-cycle shutdown request, and a 16-bit general-purpose output port. Reads are combinational while the read strobe is high. Writes take effect on the clock edge where the write strobe is high.

Top module: `board_irl_ctrl`

## Requirements
- R1: Each source input passes through SYNC_STAGES flops before it sets or clears its monitor bit. The level output is registered one edge after that, so a source change is visible at `irl_o` SYNC_STAGES+1 rising edges after it is applied. It is not visible one edge earlier.
- R2: Source k (index = priority number) owns this monitor/mask bit: k0→11, k1→9, k2→8, k3→12, k4→10, k5→6, k6→5, k7→4, k8→7, k9→14, k10→13, k11→0, k12→15. Clearing that mask bit silences the source.
- R3: A source is pending only when both its monitor bit and its mask bit are set. Among pending sources, the lowest index wins.
- R4: With no source pending the internal level is 15. `irl_o` equals the level XOR 15, so idle gives 0 and source 0 gives 15.
- R5: The mask register at byte offset 0x00 is read/write, all 16 bits. The level is computed from the value being written, so `irl_o` reflects a new mask on the same edge that stores it.
- R6: Offset 0x30 reads 0. A write there with data bit 0 = 1 sets `shutdown_req_o` high for the single cycle after the write edge. A write there with bit 0 = 0 gives no pulse.
- R7: Offset 0x32 reads the constant VERSION_ID (default 0x0010), and writes to it change nothing.
- R8: Offset 0x36 is a read/write 16-bit register that drives `gpo_o` from the edge of the write onward.
- R9: Every other offset reads 0, and a write to one leaves mask, port and level unchanged.
- R10: Synchronous active-low reset clears the mask, the output port, the synchronizers (and so the monitor), the level output and the shutdown request.
- R11: `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 13 | Interrupt lines, index = priority |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data (combinational) |
| irl_o | output | 4 | Inverted interrupt-level code |
| shutdown_req_o | output | 1 | One-cycle power-off request |
| gpo_o | output | 16 | General-purpose output port |

## Verification
The bench builds the block with its defaults: SYNC_STAGES = 2 and VERSION_ID = 0x0010. It computes the expected source latency from SYNC_STAGES, so the edge just before a change is checked as well as the edge of the change. With thirteen sources, every line can be driven alone and in overlapping groups against full and partial masks. This covers each bit position, each priority, the idle code and the top code.

// File: rtl/bil_pkg.sv
// Package: shared constants and the fixed source map of the level controller.
// Assumes priority equals source index, and fewer than 16 sources.
package bil_pkg;

    localparam int SRC_COUNT    = 13;
    localparam int WORD_W       = 16;
    localparam int WINDOW_BYTES = 64;

    localparam logic [5:0] OFS_MASK  = 6'h00;
    localparam logic [5:0] OFS_POWER = 6'h30;
    localparam logic [5:0] OFS_VER   = 6'h32;
    localparam logic [5:0] OFS_PORT  = 6'h36;

    // Monitor/mask bit owned by the source of a given priority.
    function automatic int src_bit(input int prio);
        case (prio)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            12:      return 15;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/bil_sync.sv
// Module: bank of multi-flop synchronizers, one chain per input bit.
// Assumes inputs are static levels; no pulse stretching is performed.
module bil_sync #(
    parameter int WIDTH  = 13,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // Shift every bit through the chain; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/bil_prio_enc.sv
// Module: picks the lowest pending index; reports all-ones when none pends.
// Assumes NUM_SRC < 2**LVL_W so that all-ones is never a real index.
module bil_prio_enc #(
    parameter int NUM_SRC = 13,
    parameter int LVL_W   = 4
) (
    input  logic [NUM_SRC-1:0] pending,
    output logic [LVL_W-1:0]   level
);

    // Scan from the weakest to the strongest so the lowest index wins.
    always_comb begin
        level = '1;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (pending[k]) level = LVL_W'(k);
        end
    end

endmodule

// File: rtl/bil_regs.sv
// Module: register window - mask, power-off pulse, version word, output port.
// Assumes single-cycle strobes; reads are combinational and gated by re.
module bil_regs #(
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 16,
    parameter logic [15:0] VERSION_ID = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] mask_next,
    output logic [DATA_W-1:0] port_q,
    output logic              shutdown_q
);
    import bil_pkg::*;

    logic hit_mask, hit_power, hit_ver, hit_port;

    // Decode the byte offset into one-hot register selects.
    always_comb begin
        hit_mask  = (addr == ADDR_W'(OFS_MASK));
        hit_power = (addr == ADDR_W'(OFS_POWER));
        hit_ver   = (addr == ADDR_W'(OFS_VER));
        hit_port  = (addr == ADDR_W'(OFS_PORT));
    end

    // Mask value as of the coming edge, so the level sees a write at once.
    assign mask_next = (we && hit_mask) ? wdata : mask_q;

    // Hold mask and port; raise the power-off pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '0;
            port_q     <= '0;
            shutdown_q <= 1'b0;
        end else begin
            mask_q     <= mask_next;
            shutdown_q <= we && hit_power && wdata[0];
            if (we && hit_port) port_q <= wdata;
        end
    end

    // Read mux; unmapped offsets and idle strobe return zero.
    always_comb begin
        rdata = '0;
        if (re) begin
            if (hit_mask)     rdata = mask_q;
            else if (hit_ver) rdata = DATA_W'(VERSION_ID);
            else if (hit_port) rdata = port_q;
        end
    end

endmodule

// File: rtl/board_irl_ctrl.sv
// Module: board interrupt level controller top.
// Synchronizes sources, places them on the monitor word, qualifies them with
// the mask, encodes the winner and drives the inverted code from a flop.
// Assumes source index equals priority and the map in bil_pkg.
module board_irl_ctrl #(
    parameter int          NUM_SRC     = 13,
    parameter int          SYNC_STAGES = 2,
    parameter int          DATA_W      = 16,
    parameter int          ADDR_W      = $clog2(bil_pkg::WINDOW_BYTES),
    parameter logic [15:0] VERSION_ID  = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [3:0]         irl_o,
    output logic               shutdown_req_o,
    output logic [DATA_W-1:0]  gpo_o
);
    import bil_pkg::*;

    localparam int LVL_W = 4;

    logic [NUM_SRC-1:0] src_sync;
    logic [DATA_W-1:0]  monitor;
    logic [DATA_W-1:0]  mask_q, mask_next;
    logic [NUM_SRC-1:0] pending;
    logic [LVL_W-1:0]   level;
    logic [LVL_W-1:0]   irl_q;

    bil_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_i), .q(src_sync)
    );

    bil_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION_ID(VERSION_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .re(bus_re), .rdata(bus_rdata), .mask_q(mask_q),
        .mask_next(mask_next), .port_q(gpo_o), .shutdown_q(shutdown_req_o)
    );

    // Place each synchronized source on its assigned monitor bit.
    always_comb begin
        monitor = '0;
        for (int k = 0; k < NUM_SRC; k++) monitor[src_bit(k)] = src_sync[k];
    end

    // A source pends when monitor and mask agree on its bit.
    always_comb begin
        for (int k = 0; k < NUM_SRC; k++)
            pending[k] = monitor[src_bit(k)] & mask_next[src_bit(k)];
    end

    bil_prio_enc #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_enc (
        .pending(pending), .level(level)
    );

    // Register the inverted level so idle reads as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) irl_q <= '0;
        else        irl_q <= level ^ {LVL_W{1'b1}};
    end

    assign irl_o = irl_q;

endmodule

// File: rtl/bil_checker.sv
// Module: property checker for board_irl_ctrl, attached by bind.
// Assumes mask_q is the stored mask register of the top.
module bil_checker #(
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 16,
    parameter logic [15:0] VERSION_ID = 16'h0010
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [3:0]        irl_o,
    input logic              shutdown_req_o,
    input logic [DATA_W-1:0] gpo_o,
    input logic [DATA_W-1:0] mask_q
);
    logic wr_mask, wr_power_go, wr_port, known_ofs;

    // Classify the bus access under way.
    always_comb begin
        wr_mask     = bus_we && (bus_addr == ADDR_W'(6'h00));
        wr_power_go = bus_we && (bus_addr == ADDR_W'(6'h30)) && bus_wdata[0];
        wr_port     = bus_we && (bus_addr == ADDR_W'(6'h36));
        known_ofs   = (bus_addr == ADDR_W'(6'h00)) || (bus_addr == ADDR_W'(6'h30)) ||
                      (bus_addr == ADDR_W'(6'h32)) || (bus_addr == ADDR_W'(6'h36));
    end

    assert_mask_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(bus_wdata)));

    assert_zero_mask_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && !wr_mask) |=> (irl_o == 4'd0));

    assert_power_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_power_go |=> shutdown_req_o);

    assert_power_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_power_go |=> !shutdown_req_o);

    assert_version_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(6'h32)) |-> (bus_rdata == DATA_W'(VERSION_ID)));

    assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_port |=> $stable(gpo_o));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !known_ofs) |-> (bus_rdata == '0));

    assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

endmodule

bind board_irl_ctrl bil_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION_ID(VERSION_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irl_o(irl_o),
    .shutdown_req_o(shutdown_req_o), .gpo_o(gpo_o), .mask_q(mask_q)
);

// File: tb/sim_board_irl_ctrl.sv
`timescale 1ns/1ps
// Bench: directed scenarios for board_irl_ctrl, one task each.
module sim_board_irl_ctrl;
    localparam int NSRC = 13;
    localparam int SYNC = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [5:0]      addr = '0;
    logic [15:0]     wdata = '0;
    logic            we = 1'b0;
    logic            re = 1'b0;
    logic [15:0]     rdata;
    logic [3:0]      irl;
    logic            sdn;
    logic [15:0]     gpo;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    board_irl_ctrl #(.NUM_SRC(NSRC), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata),
        .irl_o(irl), .shutdown_req_o(sdn), .gpo_o(gpo)
    );

    // Bit owned by each priority, per R2.
    function automatic int bit_of(input int k);
        int tbl [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return tbl[k];
    endfunction

    // Expected output code per R3 and R4.
    function automatic logic [3:0] exp_irl(input logic [NSRC-1:0] s, input logic [15:0] m);
        int lvl = 15;
        for (int k = NSRC - 1; k >= 0; k--)
            if (s[k] && m[bit_of(k)]) lvl = k;
        return 4'(lvl) ^ 4'hF;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        #1 d = rdata;
        re = 1'b0;
    endtask

    // Apply sources and wait out synchronizers plus output flop.
    task automatic drive_src(input logic [NSRC-1:0] s);
        @(negedge clk);
        src = s;
        repeat (SYNC + 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R10 irl after reset", 16'(irl), 16'h0);
        chk("R10 shutdown after reset", 16'(sdn), 16'h0);
        chk("R10 port after reset", gpo, 16'h0);
        bus_read(6'h00, d);
        chk("R10 mask after reset", d, 16'h0);
        src = '1;
        drive_src('1);
        chk("R10 mask zero blocks sources", 16'(irl), 16'h0);
    endtask

    task automatic t_single();
        bus_write(6'h00, 16'hFFFF);
        for (int k = 0; k < NSRC; k++) begin
            drive_src(NSRC'(1) << k);
            chk($sformatf("R2 R4 source %0d alone", k), 16'(irl), 16'(4'(k) ^ 4'hF));
            bus_write(6'h00, ~(16'h1 << bit_of(k)));
            chk($sformatf("R2 source %0d masked off", k), 16'(irl), 16'h0);
            bus_write(6'h00, 16'hFFFF);
        end
    endtask

    task automatic t_priority();
        logic [NSRC-1:0] pats [4] = '{13'h1FFF, 13'h1800, 13'h0A50, 13'h1002};
        logic [15:0]     msks [3] = '{16'hFFFF, 16'hF7FF, 16'h00F1};
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 3; m++) begin
                bus_write(6'h00, msks[m]);
                drive_src(pats[p]);
                chk($sformatf("R3 pattern %h mask %h", pats[p], msks[m]),
                    16'(irl), 16'(exp_irl(pats[p], msks[m])));
            end
        end
    endtask

    task automatic t_latency();
        logic [15:0] d;
        bus_write(6'h00, 16'hFFFF);
        drive_src('0);
        chk("R4 idle code", 16'(irl), 16'h0);
        @(negedge clk);
        src = NSRC'(1) << 7;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        chk("R1 not yet visible", 16'(irl), 16'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 visible after sync", 16'(irl), 16'(4'd7 ^ 4'hF));
        bus_write(6'h00, 16'h0000);
        chk("R5 mask clear same edge", 16'(irl), 16'h0);
        bus_write(6'h00, 16'h0010);
        chk("R5 mask set same edge", 16'(irl), 16'(4'd7 ^ 4'hF));
        bus_read(6'h00, d);
        chk("R5 mask readback", d, 16'h0010);
        drive_src('0);
        chk("R1 release clears", 16'(irl), 16'h0);
    endtask

    task automatic t_power();
        logic [15:0] d;
        bus_write(6'h30, 16'h0001);
        chk("R6 pulse high", 16'(sdn), 16'h1);
        @(negedge clk);
        chk("R6 pulse one cycle", 16'(sdn), 16'h0);
        bus_write(6'h30, 16'hFFFE);
        chk("R6 bit0 clear no pulse", 16'(sdn), 16'h0);
        bus_read(6'h30, d);
        chk("R6 reads zero", d, 16'h0);
    endtask

    task automatic t_version();
        logic [15:0] d;
        bus_read(6'h32, d);
        chk("R7 version", d, 16'h0010);
        bus_write(6'h32, 16'hABCD);
        bus_read(6'h32, d);
        chk("R7 version after write", d, 16'h0010);
    endtask

    task automatic t_port();
        logic [15:0] d;
        bus_write(6'h36, 16'h1234);
        chk("R8 port pins", gpo, 16'h1234);
        bus_read(6'h36, d);
        chk("R8 port readback", d, 16'h1234);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        logic [5:0]  ofs [4] = '{6'h02, 6'h31, 6'h34, 6'h3E};
        bus_write(6'h00, 16'h8000);
        drive_src(NSRC'(1) << 12);
        for (int i = 0; i < 4; i++) begin
            bus_write(ofs[i], 16'hFFFF);
            bus_read(ofs[i], d);
            chk($sformatf("R9 offset %h reads zero", ofs[i]), d, 16'h0);
        end
        bus_read(6'h00, d);
        chk("R9 mask untouched", d, 16'h8000);
        chk("R9 port untouched", gpo, 16'h1234);
        chk("R9 level untouched", 16'(irl), 16'(4'd12 ^ 4'hF));
        @(negedge clk);
        addr = 6'h36;
        #1 chk("R11 no strobe reads zero", rdata, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_priority();
        t_latency();
        t_power();
        t_version();
        t_port();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule